// File: doc/BRIEF.md
# Seed-Based Address-Inversion RAM Self-Test Controller

This block is a built-in self-test sequencer for a single-port synchronous SRAM with an `ADDR_W`-bit address and one cycle of read latency. It does not march over the whole array. It visits a short, non-linear list of locations. Each list is built from a background "seed" address word. The seed itself comes first, followed by copies of the seed with exactly one address bit inverted, from bit 0 up to the top bit. A larger seed set (2, 4 or 8 seeds) gives better fault coverage at a proportionally higher access count.

During the write pass every visited location receives a different word from a maximal-length LFSR. Once the write pass is complete, the read pass walks the same list backwards. It regenerates each expected word by running the same LFSR in reverse, so no written data has to be stored. The first mismatch is recorded together with its address, the expected word and the returned word. The test then runs to its end and signals completion with a one-cycle pulse.

Top module: `seedflip_bist`

## Requirements
- R1: `seed_sel` selects the seed count: 0 gives 2 seeds, 1 gives 4, 2 gives 8, and the unused code 3 behaves like 0. The value is taken only in the cycle a start is accepted.
- R2: The seeds are indexed 0 to 7 and are used in that index order. For an 8-bit address they are 8'h00, 8'hFF, 8'h0F (lower half of the bits set), 8'hF0, 8'h33 (bit i set when i mod 4 < 2), 8'hCC, 8'h55 (even bits set) and 8'hAA. A 2-seed test uses indices 0..1 and a 4-seed test uses indices 0..3.
- R3: In the write pass, each seed's group of ADDR_W+1 accesses starts with the seed address. Then come the seed with bit 0 inverted, bit 1 inverted, and so on up to bit ADDR_W-1. `ram_en` and `ram_we` are both 1 on every write cycle.
- R4: Write data comes from a 16-bit Fibonacci LFSR that shifts left. The new bit 0 is bit15^bit13^bit12^bit10. The first write carries 16'hACE1, and the register advances one step per write.
- R5: The read pass starts in the cycle after the last write. It visits the write-pass addresses in exactly reverse order, with `ram_en`=1 and `ram_we`=0. Each `ram_rdata` word is compared, one cycle after its address, with the word written to that position.
- R6: One test makes exactly 2·S·(ADDR_W+1) RAM accesses for S seeds: 4n+4, 8n+8 or 16n+16.
- R7: On the first mismatch `fail` rises and `fail_addr`, `fail_exp` and `fail_got` capture that read. Later mismatches change none of them. An accepted start clears `fail`.
- R8: A mismatch does not stop the test. `done` is a single-cycle pulse in the cycle after `busy` falls, and `fail` is already final when `done` is high.
- R9: `start` is ignored while `busy` is 1. Neither the running sequence nor its seed count changes.
- R10: During and after reset `busy`, `done`, `fail`, `ram_en` and `ram_we` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to begin a test (accepted when idle) |
| seed_sel | input | 2 | Seed-count code, taken at start |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | ADDR_W | RAM address |
| ram_wdata | output | DATA_W | RAM write data |
| ram_rdata | input | DATA_W | RAM read data, one cycle after the address |
| busy | output | 1 | Test in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | At least one mismatch seen in this test |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_exp | output | DATA_W | Expected word at the first mismatch |
| fail_got | output | DATA_W | Returned word at the first mismatch |

## Verification
The hardest situation to reach from the ports is a run with several bad locations. The reported one must be the first in read order, which is the last in write order. The expected word must then be recovered by stepping the pattern generator backwards across many positions. The bench's RAM model corrupts the read path at two chosen addresses that lie far apart in the sequence, so the reverse-ordered priority and the backward regeneration both have to be right. A start pulse with a different seed code is also injected in the middle of a write pass.

// File: rtl/seedflip_pkg.sv
package seedflip_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2,
    ST_DRAIN = 2'd3
  } sf_state_e;

  // seed-count code -> number of seeds (unused code behaves as two seeds)
  function automatic logic [3:0] seeds_for(logic [1:0] code);
    case (code)
      2'd1:    return 4'd4;
      2'd2:    return 4'd8;
      default: return 4'd2;
    endcase
  endfunction

endpackage

// File: rtl/sf_addr_seq.sv
module sf_addr_seq #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step_wr,
  input  logic              step_rd,
  input  logic [2:0]        seed_max,
  output logic [ADDR_W-1:0] addr,
  output logic              last_wr,
  output logic              last_rd
);
  localparam int JW = $clog2(ADDR_W + 1);
  localparam logic [JW-1:0] J_TOP = JW'(ADDR_W);

  logic [2:0]    s_q;
  logic [JW-1:0] j_q;

  // background word for seed index
  function automatic logic [ADDR_W-1:0] seed_word(logic [2:0] idx);
    logic [ADDR_W-1:0] w;
    for (int i = 0; i < ADDR_W; i++) begin
      case (idx)
        3'd0: w[i] = 1'b0;
        3'd1: w[i] = 1'b1;
        3'd2: w[i] = (i < ADDR_W / 2);
        3'd3: w[i] = (i >= ADDR_W / 2);
        3'd4: w[i] = ((i % 4) < 2);
        3'd5: w[i] = ((i % 4) >= 2);
        3'd6: w[i] = ((i % 2) == 0);
        default: w[i] = ((i % 2) == 1);
      endcase
    end
    return w;
  endfunction

  // slot 0 is the seed itself, slot j>0 inverts bit j-1
  function automatic logic [ADDR_W-1:0] flip_mask(logic [JW-1:0] slot);
    logic [ADDR_W-1:0] m;
    for (int i = 0; i < ADDR_W; i++) m[i] = (int'(slot) == i + 1);
    return m;
  endfunction

  assign addr    = seed_word(s_q) ^ flip_mask(j_q);
  assign last_wr = (s_q == seed_max) && (j_q == J_TOP);
  assign last_rd = (s_q == 3'd0) && (j_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q <= '0;
      j_q <= '0;
    end else if (clear) begin
      s_q <= '0;
      j_q <= '0;
    end else if (step_wr) begin
      if (j_q == J_TOP) begin
        j_q <= '0;
        s_q <= s_q + 3'd1;
      end else begin
        j_q <= j_q + 1'b1;
      end
    end else if (step_rd) begin
      if (j_q == '0) begin
        j_q <= J_TOP;
        s_q <= s_q - 3'd1;
      end else begin
        j_q <= j_q - 1'b1;
      end
    end
  end

  a_r3_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
    j_q <= J_TOP) else $error("slot index beyond address width");

endmodule

// File: rtl/sf_lfsr.sv
module sf_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] INIT = W'(16'hACE1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         fwd,
  input  logic         back,
  output logic [W-1:0] value,
  output logic [W-1:0] prev
);
  function automatic logic [W-1:0] bit_at(int pos);
    return {{(W-1){1'b0}}, 1'b1} << pos;
  endfunction

  function automatic logic [W-1:0] tap_mask();
    case (W)
      8:  return bit_at(7)  | bit_at(5)  | bit_at(4)  | bit_at(3);
      16: return bit_at(15) | bit_at(13) | bit_at(12) | bit_at(10);
      24: return bit_at(23) | bit_at(22) | bit_at(21) | bit_at(16);
      32: return bit_at(31) | bit_at(21) | bit_at(1)  | bit_at(0);
      default: return bit_at(W-1) | bit_at(W-2);
    endcase
  endfunction

  localparam logic [W-1:0] TAP = tap_mask();

  function automatic logic [W-1:0] step_fwd(logic [W-1:0] x);
    return {x[W-2:0], ^(x & TAP)};
  endfunction

  // inverse of step_fwd: top tap is always set, so the lost bit is recoverable
  function automatic logic [W-1:0] step_back(logic [W-1:0] y);
    logic [W-1:0] x;
    x[W-2:0] = y[W-1:1];
    x[W-1]   = y[0] ^ (^(x[W-2:0] & TAP[W-2:0]));
    return x;
  endfunction

  logic [W-1:0] r_q;

  assign value = r_q;
  assign prev  = step_back(r_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     r_q <= INIT;
    else if (load)  r_q <= INIT;
    else if (fwd)   r_q <= step_fwd(r_q);
    else if (back)  r_q <= prev;
  end

  a_r4_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    r_q != '0) else $error("pattern register reached the lock-up state");

endmodule

// File: rtl/sf_check.sv
module sf_check #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              issue,
  input  logic [ADDR_W-1:0] issue_addr,
  input  logic [DATA_W-1:0] issue_exp,
  input  logic [DATA_W-1:0] rdata,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [DATA_W-1:0] fail_exp,
  output logic [DATA_W-1:0] fail_got
);
  logic              pend_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] exp_q;
  logic              fail_q;
  logic [ADDR_W-1:0] fa_q;
  logic [DATA_W-1:0] fe_q, fg_q;
  logic              mismatch;
  logic              capture;

  assign mismatch = pend_q && (rdata != exp_q);
  assign capture  = mismatch && !fail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      addr_q <= '0;
      exp_q  <= '0;
    end else begin
      pend_q <= issue;
      if (issue) begin
        addr_q <= issue_addr;
        exp_q  <= issue_exp;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q <= 1'b0;
      fa_q   <= '0;
      fe_q   <= '0;
      fg_q   <= '0;
    end else if (clear) begin
      fail_q <= 1'b0;
    end else if (capture) begin
      fail_q <= 1'b1;
      fa_q   <= addr_q;
      fe_q   <= exp_q;
      fg_q   <= rdata;
    end
  end

  assign fail      = fail_q;
  assign fail_addr = fa_q;
  assign fail_exp  = fe_q;
  assign fail_got  = fg_q;

  a_r7_first_held: assert property (@(posedge clk) disable iff (!rst_n)
    fail_q && !clear |=> fail_q && $stable(fa_q) && $stable(fe_q) && $stable(fg_q))
    else $error("first-failure record changed");

endmodule

// File: rtl/seedflip_bist.sv
module seedflip_bist #(
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 16,
  parameter logic [DATA_W-1:0] LFSR_INIT = DATA_W'(16'hACE1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        seed_sel,
  output logic              ram_en,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [DATA_W-1:0] fail_exp,
  output logic [DATA_W-1:0] fail_got
);
  import seedflip_pkg::*;

  sf_state_e         state_q;
  logic [2:0]        seed_max_q;
  logic              done_q;
  logic              start_acc;
  logic              in_wr, in_rd;
  logic              last_wr, last_rd;
  logic [ADDR_W-1:0] seq_addr;
  logic [DATA_W-1:0] pat_now, pat_prev;

  assign start_acc = (state_q == ST_IDLE) && start;
  assign in_wr     = (state_q == ST_WRITE);
  assign in_rd     = (state_q == ST_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      seed_max_q <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q <= (state_q == ST_DRAIN);
      case (state_q)
        ST_IDLE: if (start_acc) begin
          state_q    <= ST_WRITE;
          seed_max_q <= 3'(seeds_for(seed_sel) - 4'd1);
        end
        ST_WRITE: if (last_wr) state_q <= ST_READ;
        ST_READ:  if (last_rd) state_q <= ST_DRAIN;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  sf_addr_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start_acc),
    .step_wr  (in_wr && !last_wr),
    .step_rd  (in_rd && !last_rd),
    .seed_max (seed_max_q),
    .addr     (seq_addr),
    .last_wr  (last_wr),
    .last_rd  (last_rd)
  );

  sf_lfsr #(.W(DATA_W), .INIT(LFSR_INIT)) u_pat (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (start_acc),
    .fwd   (in_wr),
    .back  (in_rd),
    .value (pat_now),
    .prev  (pat_prev)
  );

  sf_check #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (start_acc),
    .issue      (in_rd),
    .issue_addr (seq_addr),
    .issue_exp  (pat_prev),
    .rdata      (ram_rdata),
    .fail       (fail),
    .fail_addr  (fail_addr),
    .fail_exp   (fail_exp),
    .fail_got   (fail_got)
  );

  assign ram_en    = in_wr || in_rd;
  assign ram_we    = in_wr;
  assign ram_addr  = seq_addr;
  assign ram_wdata = pat_now;
  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q) else $error("done longer than one cycle");

  a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy && $past(busy)) else $error("done not at end of a run");

  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(seed_max_q)) else $error("seed count changed while busy");

  a_r5_no_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    in_rd |=> !ram_we) else $error("write issued during read pass");

endmodule

// File: tb/seedflip_bist_bench.sv
module seedflip_bist_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  seed_sel = 2'd0;
  logic        ram_en, ram_we;
  logic [7:0]  ram_addr;
  logic [15:0] ram_wdata;
  logic [15:0] ram_rdata = '0;
  logic        busy, done, fail;
  logic [7:0]  fail_addr;
  logic [15:0] fail_exp, fail_got;

  int total = 0;
  int bad = 0;

  logic [7:0]  flt_a0 = '0, flt_a1 = '0;
  logic [15:0] flt_m0 = '0, flt_m1 = '0;
  logic [15:0] mem [0:255];

  always #4 clk = ~clk;

  seedflip_bist u_seedflip_bist (
    .clk(clk), .rst_n(rst_n), .start(start), .seed_sel(seed_sel),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .busy(busy), .done(done),
    .fail(fail), .fail_addr(fail_addr), .fail_exp(fail_exp), .fail_got(fail_got)
  );

  // single-port RAM model, one-cycle read latency, optional read corruption
  always @(posedge clk) begin
    if (ram_en && ram_we) mem[ram_addr] <= ram_wdata;
    ram_rdata <= mem[ram_addr]
               ^ ((ram_addr == flt_a0) ? flt_m0 : 16'h0)
               ^ ((ram_addr == flt_a1) ? flt_m1 : 16'h0);
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_addr(int k);
    int s = k / 9;
    int j = k % 9;
    logic [7:0] sd;
    case (s)
      0: sd = 8'h00;  1: sd = 8'hFF;  2: sd = 8'h0F;  3: sd = 8'hF0;
      4: sd = 8'h33;  5: sd = 8'hCC;  6: sd = 8'h55;  default: sd = 8'hAA;
    endcase
    return (j == 0) ? sd : (sd ^ (8'h01 << (j - 1)));
  endfunction

  function automatic logic [15:0] exp_data(int k);
    logic [15:0] x = 16'hACE1;
    for (int i = 0; i < k; i++) x = {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
    return x;
  endfunction

  task automatic run(input logic [1:0] sel, input int nseed, input bit mid,
                     input bit exp_fail, input logic [7:0] e_addr,
                     input logic [15:0] e_exp, input logic [15:0] e_got);
    logic [7:0]  wa [0:127];
    logic [15:0] wd [0:127];
    logic [7:0]  ra [0:127];
    int nw = 0, nr = 0, cyc = 0, dw = 0, len, errs;
    bit seen = 0, fin = 0;
    logic f = 0;
    logic [7:0] fa = '0;
    logic [15:0] fe = '0, fg = '0;
    len = nseed * 9;
    @(negedge clk); start = 1'b1; seed_sel = sel;
    @(negedge clk); start = 1'b0;
    while (!fin && cyc < 3000) begin
      if (ram_en && ram_we && nw < 128) begin wa[nw] = ram_addr; wd[nw] = ram_wdata; nw++; end
      else if (ram_en && !ram_we && nr < 128) begin ra[nr] = ram_addr; nr++; end
      if (done) begin
        dw++;
        if (!seen) begin seen = 1; f = fail; fa = fail_addr; fe = fail_exp; fg = fail_got; end
      end else if (seen) fin = 1;
      // R9: a second start with another code in mid write pass
      start = mid && (nw == 5);
      seed_sel = mid ? 2'd2 : sel;
      @(negedge clk); cyc++;
    end
    start = 1'b0;
    if (!fin) chk(0, "R8", "watchdog expired", cyc, 0);
    chk(nw + nr == 2 * len, "R6_R1", "access count", nw + nr, 2 * len);
    chk(nw == len, "R3", "write count", nw, len);
    errs = 0;
    for (int k = 0; k < nw && k < len; k++) if (wa[k] !== exp_addr(k)) errs++;
    chk(errs == 0, "R3_R2", "write address order errors", errs, 0);
    errs = 0;
    for (int k = 0; k < nw && k < len; k++) if (wd[k] !== exp_data(k)) errs++;
    chk(errs == 0, "R4", "write data errors", errs, 0);
    chk(nr == len, "R5", "read count", nr, len);
    errs = 0;
    for (int k = 0; k < nr && k < len; k++) if (ra[k] !== exp_addr(len - 1 - k)) errs++;
    chk(errs == 0, "R5", "reverse read order errors", errs, 0);
    chk(dw == 1 && !busy, "R8", "done pulse width", dw, 1);
    chk(f == exp_fail, "R7", "fail flag at done", f, exp_fail);
    if (exp_fail) begin
      chk(fa == e_addr, "R7", "first fail address", fa, e_addr);
      chk(fe == e_exp,  "R7", "first fail expected word", fe, e_exp);
      chk(fg == e_got,  "R7", "first fail returned word", fg, e_got);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(!busy && !done && !fail && !ram_en && !ram_we, "R10", "reset outputs",
        {busy, done, fail, ram_en, ram_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !fail && !ram_en, "R10", "idle after reset",
        {busy, done, fail, ram_en}, 0);
    // R9: mid-run start must not turn the 2-seed run into an 8-seed run
    run(2'd0, 2, 1'b1, 1'b0, '0, '0, '0);
    run(2'd1, 4, 1'b0, 1'b0, '0, '0, '0);
    run(2'd2, 8, 1'b0, 1'b0, '0, '0, '0);
    // R1: unused code behaves as two seeds
    run(2'd3, 2, 1'b0, 1'b0, '0, '0, '0);
    // R7/R8: single corrupted location (seed 0xF0 with bit 3 inverted, position 31)
    flt_a0 = 8'hF8; flt_m0 = 16'h0100;
    run(2'd1, 4, 1'b0, 1'b1, 8'hF8, exp_data(31), exp_data(31) ^ 16'h0100);
    // R7: two corrupted locations; 0xAA (position 63) is read before 0x01 (position 1)
    flt_a0 = 8'h01; flt_m0 = 16'h0001;
    flt_a1 = 8'hAA; flt_m1 = 16'h8000;
    run(2'd2, 8, 1'b0, 1'b1, 8'hAA, exp_data(63), exp_data(63) ^ 16'h8000);
    // R7: a new start clears the fail record
    flt_m0 = '0; flt_m1 = '0;
    run(2'd0, 2, 1'b0, 1'b0, '0, '0, '0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule